// File: doc/BRIEF.md
# Radio packet status register

This block maintains the read-only packet status byte of a packet radio receiver. Each bit of the byte has its own rule: some are loaded by receive events, some are sticky across state changes, and some are cleared when the radio enters a particular operating state. The byte is held in registers, so a host read path can sample it directly.

The block watches five kinds of input. The first is a two-bit radio state. The second is a set of single-cycle event strobes from the receive chain: CRC verdict, sync word, end of packet, and filter drop. The third is the carrier-sense level. The fourth is the measured preamble quality together with its programmed threshold. The fifth is the two general-purpose output pins together with the inversion setting of each. Entry into a state is found inside the block by comparing the present state with the one registered on the previous cycle. A separate restart strobe marks a receive restart that does not leave RX.

Top module: `pkt_status_reg`

## Requirements
- R1: The byte layout from bit 7 down to bit 0 is: CRC match, carrier sense, preamble reached, channel clear, start of frame, pin-2 value, a constant 0, pin-0 value. Radio state codes are IDLE=0, RX=1, TX=2, RX-overflow=3.
- R2: A cycle with `rst` high clears every bit of `status` at that clock edge.
- R3: When `crc_valid` is high, bit 7 takes `crc_ok` at the next edge. Bit 7 clears when RX is entered from another state, or when `rx_restart` is high while in RX.
- R4: While in RX, bit 6 follows `cs_in` one cycle later. Entering IDLE clears bit 6. In TX and RX-overflow, bit 6 holds its value.
- R5: Bit 5 sets while in RX with `pq_level >= pq_thresh`. It keeps its value after RX is left. It clears on RX entry or restart, and in any cycle where `pq_level < pq_thresh`.
- R6: Bit 3 sets on `sync_det` while in RX. It clears on `eop`, on `pkt_drop`, and on entry into RX-overflow.
- R7: In any cycle where the state is TX, bit 3 is cleared, so it reads 0 from the next cycle for as long as TX lasts.
- R8: Bit 4 equals the inverse of `cs_in` of the previous cycle when that cycle was in RX. Otherwise bit 4 is 0.
- R9: Bits 2 and 0 report `gpo2_pin ^ gpo2_inv` and `gpo0_pin ^ gpo0_inv` respectively, delayed by `GPO_SYNC_STAGES` clock cycles (default 2). This is the non-inverted value whatever the inversion setting is.
- R10: When a set event and a clear condition for the same bit fall in the same cycle, the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| radio_state | input | 2 | Operating state: 0 IDLE, 1 RX, 2 TX, 3 RX-overflow |
| rx_restart | input | 1 | Receive restarted while staying in RX |
| crc_valid | input | 1 | CRC verdict strobe |
| crc_ok | input | 1 | CRC verdict, 1 = match |
| sync_det | input | 1 | Sync word received strobe |
| eop | input | 1 | End-of-packet strobe |
| pkt_drop | input | 1 | Packet dropped by address or length filter |
| cs_in | input | 1 | Carrier sense level |
| pq_level | input | PQ_W | Measured preamble quality |
| pq_thresh | input | PQ_W | Programmed preamble quality threshold |
| gpo2_pin | input | 1 | Driven level of output pin 2 |
| gpo2_inv | input | 1 | Inversion setting of pin 2 |
| gpo0_pin | input | 1 | Driven level of output pin 0 |
| gpo0_inv | input | 1 | Inversion setting of pin 0 |
| status | output | 8 | Assembled status byte |

## Verification
The hardest situation to create is a sticky preamble-reached bit outside RX. It needs a stretch in RX with quality at or above the threshold, followed by an exit to TX or IDLE while the quality stays high enough that the below-threshold clear does not hide the stickiness. The random stimulus uses a narrow quality field and changes the threshold only rarely. A directed sequence also walks RX, then TX, then back to RX with the quality held high, so that both the hold and the clear on re-entry are seen. Same-cycle collisions of set and clear are forced by directed steps: RX entry with a passing CRC verdict, and a sync word together with end of packet.

// File: rtl/pkt_status_pkg.sv
package pkt_status_pkg;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_RX    = 2'd1,
      RS_TX    = 2'd2,
      RS_RXOVF = 2'd3
   } radio_state_e;

   localparam int STATUS_W  = 8;
   localparam int BIT_CRC   = 7;
   localparam int BIT_CS    = 6;
   localparam int BIT_PQT   = 5;
   localparam int BIT_CCA   = 4;
   localparam int BIT_SFD   = 3;
   localparam int BIT_GPO2  = 2;
   localparam int BIT_RSVD  = 1;
   localparam int BIT_GPO0  = 0;
   localparam int GPO_COUNT = 2;

endpackage

// File: rtl/pkt_status_gpo_sync.sv
module pkt_status_gpo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin,
   input  logic inv,
   output logic val
);

   logic [STAGES-1:0] pipe;

   // undo the pin inversion before the value enters the chain
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) pipe[s] <= 1'b0;
            else     pipe[s] <= pin ^ inv;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) pipe[s] <= 1'b0;
            else     pipe[s] <= pipe[s-1];
         end
      end
   end

   assign val = pipe[STAGES-1];

endmodule

// File: rtl/pkt_status_rx_flags.sv
module pkt_status_rx_flags (
   input  logic clk,
   input  logic rst,
   input  logic in_rx,
   input  logic in_tx,
   input  logic rx_enter,
   input  logic ovf_enter,
   input  logic crc_valid,
   input  logic crc_ok,
   input  logic sync_det,
   input  logic eop,
   input  logic pkt_drop,
   input  logic pq_ok,
   output logic crc_q,
   output logic pqt_q,
   output logic sfd_q
);

   logic sfd_clr;
   logic pqt_clr;

   assign sfd_clr = eop | pkt_drop | ovf_enter | in_tx;
   assign pqt_clr = rx_enter | ~pq_ok;

   // clear terms are tested first so they win over a coincident set
   always_ff @(posedge clk) begin
      if (rst) begin
         crc_q <= 1'b0;
         pqt_q <= 1'b0;
         sfd_q <= 1'b0;
      end else begin
         if (rx_enter)       crc_q <= 1'b0;
         else if (crc_valid) crc_q <= crc_ok;

         if (pqt_clr)        pqt_q <= 1'b0;
         else if (in_rx)     pqt_q <= 1'b1;

         if (sfd_clr)                sfd_q <= 1'b0;
         else if (in_rx && sync_det) sfd_q <= 1'b1;
      end
   end

endmodule

// File: rtl/pkt_status_link.sv
module pkt_status_link (
   input  logic clk,
   input  logic rst,
   input  logic in_rx,
   input  logic idle_enter,
   input  logic cs_in,
   output logic cs_q,
   output logic cca_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_q  <= 1'b0;
         cca_q <= 1'b0;
      end else begin
         if (idle_enter) cs_q <= 1'b0;
         else if (in_rx) cs_q <= cs_in;
         cca_q <= in_rx & ~cs_in;
      end
   end

endmodule

// File: rtl/pkt_status_reg.sv
module pkt_status_reg
   import pkt_status_pkg::*;
#(
   parameter int PQ_W            = 4,
   parameter int GPO_SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      radio_state,
   input  logic            rx_restart,
   input  logic            crc_valid,
   input  logic            crc_ok,
   input  logic            sync_det,
   input  logic            eop,
   input  logic            pkt_drop,
   input  logic            cs_in,
   input  logic [PQ_W-1:0] pq_level,
   input  logic [PQ_W-1:0] pq_thresh,
   input  logic            gpo2_pin,
   input  logic            gpo2_inv,
   input  logic            gpo0_pin,
   input  logic            gpo0_inv,
   output logic [7:0]      status
);

   initial begin : elab_checks
      assert (PQ_W >= 1 && PQ_W <= 16)
         else $fatal(1, "PQ_W must lie in 1..16");
      assert (GPO_SYNC_STAGES >= 1 && GPO_SYNC_STAGES <= 4)
         else $fatal(1, "GPO_SYNC_STAGES must lie in 1..4");
      assert (STATUS_W == 8)
         else $fatal(1, "status byte must be 8 bits");
   end

   radio_state_e st_now;
   radio_state_e st_q;
   logic in_rx, in_tx, rx_enter, idle_enter, ovf_enter, pq_ok;
   logic crc_q, pqt_q, sfd_q, cs_q, cca_q;
   logic [GPO_COUNT-1:0] g_pin, g_inv, g_val;

   assign st_now = radio_state_e'(radio_state);

   always_ff @(posedge clk) begin
      if (rst) st_q <= RS_IDLE;
      else     st_q <= st_now;
   end

   assign in_rx      = (st_now == RS_RX);
   assign in_tx      = (st_now == RS_TX);
   assign rx_enter   = in_rx && ((st_q != RS_RX) || rx_restart);
   assign idle_enter = (st_now == RS_IDLE) && (st_q != RS_IDLE);
   assign ovf_enter  = (st_now == RS_RXOVF) && (st_q != RS_RXOVF);
   assign pq_ok      = (pq_level >= pq_thresh);

   pkt_status_rx_flags u_rx_flags (
      .clk       (clk),
      .rst       (rst),
      .in_rx     (in_rx),
      .in_tx     (in_tx),
      .rx_enter  (rx_enter),
      .ovf_enter (ovf_enter),
      .crc_valid (crc_valid),
      .crc_ok    (crc_ok),
      .sync_det  (sync_det),
      .eop       (eop),
      .pkt_drop  (pkt_drop),
      .pq_ok     (pq_ok),
      .crc_q     (crc_q),
      .pqt_q     (pqt_q),
      .sfd_q     (sfd_q)
   );

   pkt_status_link u_link (
      .clk        (clk),
      .rst        (rst),
      .in_rx      (in_rx),
      .idle_enter (idle_enter),
      .cs_in      (cs_in),
      .cs_q       (cs_q),
      .cca_q      (cca_q)
   );

   assign g_pin = {gpo2_pin, gpo0_pin};
   assign g_inv = {gpo2_inv, gpo0_inv};

   for (genvar i = 0; i < GPO_COUNT; i++) begin : g_gpo
      pkt_status_gpo_sync #(.STAGES(GPO_SYNC_STAGES)) u_sync (
         .clk (clk),
         .rst (rst),
         .pin (g_pin[i]),
         .inv (g_inv[i]),
         .val (g_val[i])
      );
   end

   always_comb begin
      status           = '0;
      status[BIT_CRC]  = crc_q;
      status[BIT_CS]   = cs_q;
      status[BIT_PQT]  = pqt_q;
      status[BIT_CCA]  = cca_q;
      status[BIT_SFD]  = sfd_q;
      status[BIT_GPO2] = g_val[1];
      status[BIT_RSVD] = 1'b0;
      status[BIT_GPO0] = g_val[0];
   end

endmodule

// File: rtl/pkt_status_chk.sv
module pkt_status_chk #(
   parameter int PQ_W            = 4,
   parameter int GPO_SYNC_STAGES = 2
) (
   input logic            clk,
   input logic            rst,
   input logic [1:0]      radio_state,
   input logic            rx_restart,
   input logic            crc_valid,
   input logic            crc_ok,
   input logic            sync_det,
   input logic            eop,
   input logic            pkt_drop,
   input logic            cs_in,
   input logic [PQ_W-1:0] pq_level,
   input logic [PQ_W-1:0] pq_thresh,
   input logic            gpo2_pin,
   input logic            gpo2_inv,
   input logic            gpo0_pin,
   input logic            gpo0_inv,
   input logic [7:0]      status
);

   logic [1:0] prev_st;
   logic [2:0] warm_cnt;
   logic       rx_ent, idle_ent, ovf_ent, warm;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_st  <= 2'd0;
         warm_cnt <= '0;
      end else begin
         prev_st <= radio_state;
         if (warm_cnt != 3'd7) warm_cnt <= warm_cnt + 3'd1;
      end
   end

   assign rx_ent   = (radio_state == 2'd1) && ((prev_st != 2'd1) || rx_restart);
   assign idle_ent = (radio_state == 2'd0) && (prev_st != 2'd0);
   assign ovf_ent  = (radio_state == 2'd3) && (prev_st != 2'd3);
   assign warm     = (int'(warm_cnt) >= GPO_SYNC_STAGES);

   p_reset_clear_r2: assert property (@(posedge clk)
      rst |=> (status == 8'h00));

   p_crc_clear_entry_r3: assert property (@(posedge clk) disable iff (rst)
      rx_ent |=> !status[7]);

   p_crc_load_r3: assert property (@(posedge clk) disable iff (rst)
      (crc_valid && !rx_ent) |=> (status[7] == $past(crc_ok)));

   p_cs_clear_idle_r4: assert property (@(posedge clk) disable iff (rst)
      idle_ent |=> !status[6]);

   p_cs_follow_r4: assert property (@(posedge clk) disable iff (rst)
      (radio_state == 2'd1) |=> (status[6] == $past(cs_in)));

   p_pqt_below_r5: assert property (@(posedge clk) disable iff (rst)
      (pq_level < pq_thresh) |=> !status[5]);

   p_pqt_hold_r5: assert property (@(posedge clk) disable iff (rst)
      ((radio_state != 2'd1) && (pq_level >= pq_thresh)) |=> $stable(status[5]));

   p_sfd_set_r6: assert property (@(posedge clk) disable iff (rst)
      ((radio_state == 2'd1) && sync_det && !eop && !pkt_drop) |=> status[3]);

   p_sfd_clear_r10: assert property (@(posedge clk) disable iff (rst)
      (eop || pkt_drop || ovf_ent) |=> !status[3]);

   p_sfd_tx_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (radio_state == 2'd2) |=> !status[3]);

   p_cca_outside_rx_r8: assert property (@(posedge clk) disable iff (rst)
      (radio_state != 2'd1) |=> !status[4]);

   p_gpo0_value_r9: assert property (@(posedge clk) disable iff (rst)
      warm |-> (status[0] == $past(gpo0_pin ^ gpo0_inv, GPO_SYNC_STAGES)));

   p_gpo2_value_r9: assert property (@(posedge clk) disable iff (rst)
      warm |-> (status[2] == $past(gpo2_pin ^ gpo2_inv, GPO_SYNC_STAGES)));

endmodule

bind pkt_status_reg pkt_status_chk #(
   .PQ_W            (PQ_W),
   .GPO_SYNC_STAGES (GPO_SYNC_STAGES)
) u_pkt_status_chk (.*);

// File: tb/test_pkt_status_reg.sv
module test_pkt_status_reg;

   localparam int PQ_W = 4;
   localparam int GSTG = 2;

   logic clk = 1'b0;
   logic rst;
   logic [1:0] radio_state;
   logic rx_restart, crc_valid, crc_ok, sync_det, eop, pkt_drop, cs_in;
   logic [PQ_W-1:0] pq_level, pq_thresh;
   logic gpo2_pin, gpo2_inv, gpo0_pin, gpo0_inv;
   logic [7:0] status;

   int checks = 0;
   int fails  = 0;
   string phase = "reset";

   // reference model state
   logic [1:0] m_prev;
   logic m_crc, m_cs, m_pqt, m_sfd, m_cca;
   logic [GSTG-1:0] m_g0, m_g2;

   always #2 clk = ~clk;

   pkt_status_reg #(.PQ_W(PQ_W), .GPO_SYNC_STAGES(GSTG)) i_pkt_status_reg (
      .clk (clk), .rst (rst), .radio_state (radio_state), .rx_restart (rx_restart),
      .crc_valid (crc_valid), .crc_ok (crc_ok), .sync_det (sync_det), .eop (eop),
      .pkt_drop (pkt_drop), .cs_in (cs_in), .pq_level (pq_level), .pq_thresh (pq_thresh),
      .gpo2_pin (gpo2_pin), .gpo2_inv (gpo2_inv), .gpo0_pin (gpo0_pin),
      .gpo0_inv (gpo0_inv), .status (status)
   );

   function automatic string bit_req(int b);
      case (b)
         7: return "R3";
         6: return "R4";
         5: return "R5";
         4: return "R8";
         3: return (radio_state == 2'd2) ? "R7" : "R6";
         1: return "R1";
         default: return "R9";
      endcase
   endfunction

   task automatic model_step();
      logic rxe, ide, ovf, pq_ok;
      if (rst) begin
         {m_crc, m_cs, m_pqt, m_sfd, m_cca} = '0;
         m_g0 = '0; m_g2 = '0; m_prev = 2'd0;
      end else begin
         rxe   = (radio_state == 2'd1) && ((m_prev != 2'd1) || rx_restart);
         ide   = (radio_state == 2'd0) && (m_prev != 2'd0);
         ovf   = (radio_state == 2'd3) && (m_prev != 2'd3);
         pq_ok = (pq_level >= pq_thresh);
         if (rxe) m_crc = 1'b0;
         else if (crc_valid) m_crc = crc_ok;
         if (ide) m_cs = 1'b0;
         else if (radio_state == 2'd1) m_cs = cs_in;
         if (rxe || !pq_ok) m_pqt = 1'b0;
         else if (radio_state == 2'd1) m_pqt = 1'b1;
         if (eop || pkt_drop || ovf || radio_state == 2'd2) m_sfd = 1'b0;
         else if (radio_state == 2'd1 && sync_det) m_sfd = 1'b1;
         m_cca = (radio_state == 2'd1) && !cs_in;
         m_g0 = {m_g0[GSTG-2:0], gpo0_pin ^ gpo0_inv};
         m_g2 = {m_g2[GSTG-2:0], gpo2_pin ^ gpo2_inv};
         m_prev = radio_state;
      end
   endtask

   // one clock: inputs sampled at posedge, outputs compared at negedge
   task automatic tick();
      logic [7:0] exp_v;
      @(posedge clk);
      @(negedge clk);
      model_step();
      exp_v = {m_crc, m_cs, m_pqt, m_cca, m_sfd, m_g2[GSTG-1], 1'b0, m_g0[GSTG-1]};
      for (int b = 0; b < 8; b++) begin
         checks++;
         if (status[b] !== exp_v[b]) begin
            fails++;
            $display("FAIL %s [%s] bit %0d actual %b expected %b",
                     bit_req(b), phase, b, status[b], exp_v[b]);
         end
      end
   endtask

   task automatic quiet();
      rx_restart = 0; crc_valid = 0; crc_ok = 0; sync_det = 0; eop = 0; pkt_drop = 0;
   endtask

   task automatic rand_inputs();
      if ($urandom_range(7) == 0) radio_state = 2'($urandom_range(3));
      rx_restart = ($urandom_range(15) == 0);
      crc_valid  = ($urandom_range(5) == 0);
      crc_ok     = 1'($urandom_range(1));
      sync_det   = ($urandom_range(4) == 0);
      eop        = ($urandom_range(6) == 0);
      pkt_drop   = ($urandom_range(9) == 0);
      if ($urandom_range(3) == 0) cs_in = ~cs_in;
      pq_level   = PQ_W'($urandom_range(15));
      if ($urandom_range(31) == 0) pq_thresh = PQ_W'($urandom_range(15));
      gpo0_pin = 1'($urandom_range(1)); gpo2_pin = 1'($urandom_range(1));
      if ($urandom_range(9) == 0) gpo0_inv = ~gpo0_inv;
      if ($urandom_range(9) == 0) gpo2_inv = ~gpo2_inv;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin : watchdog
      #(4ns * 150000);
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin : stimulus
      void'($urandom(32'h5A17));
      rst = 1; radio_state = 2'd0; quiet(); cs_in = 0;
      pq_level = 0; pq_thresh = 4'd6;
      gpo0_pin = 0; gpo2_pin = 0; gpo0_inv = 0; gpo2_inv = 0;

      // R2: reset value, with pins and events active during reset
      phase = "R2 reset";
      gpo0_pin = 1; gpo2_inv = 1; crc_valid = 1; crc_ok = 1;
      tick(); tick();
      checks++;
      if (status !== 8'h00) begin
         fails++;
         $display("FAIL R2 reset byte actual %h expected 00", status);
      end
      rst = 0; quiet();

      // R10: RX entry together with a passing CRC and good preamble quality
      phase = "R10 entry collision";
      radio_state = 2'd1; crc_valid = 1; crc_ok = 1; pq_level = 4'd9;
      tick(); quiet(); tick();
      // R10: sync word together with end of packet
      phase = "R10 sfd collision";
      sync_det = 1; eop = 1; tick(); quiet(); tick();

      // R5: sticky preamble bit across TX, then cleared on RX re-entry
      phase = "R5 sticky";
      radio_state = 2'd2; tick(); tick(); tick();
      radio_state = 2'd0; tick(); tick();
      radio_state = 2'd1; tick(); tick();

      // R7: start of frame set in RX, forced low in TX
      phase = "R7 tx";
      sync_det = 1; tick(); quiet(); tick();
      radio_state = 2'd2; tick(); tick();

      // R6: start of frame cleared on overflow entry and on filter drop
      phase = "R6 overflow";
      radio_state = 2'd1; tick(); sync_det = 1; tick(); quiet();
      radio_state = 2'd3; tick(); tick();
      phase = "R6 drop";
      radio_state = 2'd1; sync_det = 1; tick(); quiet();
      pkt_drop = 1; tick(); quiet(); tick();

      // R3: restart inside RX clears CRC bit
      phase = "R3 restart";
      crc_valid = 1; crc_ok = 1; tick(); quiet();
      rx_restart = 1; tick(); quiet(); tick();

      // R4 / R8: carrier sense in RX, then IDLE entry
      phase = "R4 cs";
      cs_in = 1; tick(); tick(); cs_in = 0; tick(); cs_in = 1; tick();
      radio_state = 2'd0; tick(); tick();

      // R9: inversion settings across all four combinations
      phase = "R9 pins";
      for (int k = 0; k < 8; k++) begin
         {gpo0_inv, gpo2_inv, gpo0_pin} = 3'(k); gpo2_pin = ~gpo0_pin;
         tick();
      end

      phase = "random";
      for (int n = 0; n < 6000; n++) begin
         rand_inputs();
         if (n == 3000) rst = 1;
         if (n == 3003) rst = 0;
         tick();
      end
      finish_run();
   end

endmodule